// File: doc/BRIEF.md
# Output Port Clock Divider with Mode Latch

This block produces the bit clock and the frame clock for an audio output port that acts as clock master. A three-bit mode word chooses how the clocks are made. Four master settings divide the master clock, whose rate is 256, 384, 512 or 768 times the sample rate, down to a bit clock at 64 times the sample rate. A frame clock at the sample rate is then derived from that bit clock. A slave setting leaves both clock outputs low and ignores the master clock. A bypass setting passes a pair of externally supplied bit and frame clocks straight through to the outputs. The two remaining codes are reserved. They hold the outputs low and raise an error flag.

The mode word is captured on every master clock edge while power-down is high. It is frozen when power-down goes low, so the value sampled last before release is the one that governs. Changes to the mode word during operation therefore have no effect. While power-down is high, the dividers are held at zero and both clock outputs are low.

Top module: `aud_mclk_gen`

## Requirements
- R1: In modes 000, 001, 010 and 011, bclk_o has a period of 4, 6, 8 and 12 mclk_i cycles respectively, and stays high for exactly half of each period.
- R2: In a dividing mode, fclk_o is high for 32 bit-clock periods and low for 32 (a period of 64 bclk_o periods), and it changes only on the same mclk_i edge on which bclk_o falls.
- R3: While pwrdn_i is high, bclk_o, fclk_o and div_run_o are all low.
- R4: The mode used is the value mode_i held on the last mclk_i edge before pwrdn_i went low; changes to mode_i while pwrdn_i is low do not alter the clock periods.
- R5: In mode 100 (slave), bclk_o, fclk_o, div_run_o and mode_err_o stay low.
- R6: In modes 101 and 110 (reserved), bclk_o and fclk_o stay low and mode_err_o is high.
- R7: In mode 111 (bypass) with pwrdn_i low, bclk_o equals byp_bclk_i and fclk_o equals byp_fclk_i without delay, and mode_err_o is low.
- R8: During reset and afterwards, until a mode has been captured under power-down, all outputs are low; the default mode is slave.
- R9: After pwrdn_i falls, bclk_o first rises on mclk_i rising edge N/2 and fclk_o first rises on edge 32*N, where N is the division ratio and edge 1 is the first edge that samples pwrdn_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwrdn_i | input | 1 | Power-down, active high; the mode is captured while high |
| mode_i | input | 3 | Mode word: 000-011 ratios 256/384/512/768, 100 slave, 101/110 reserved, 111 bypass |
| byp_bclk_i | input | 1 | Bit clock forwarded in bypass mode |
| byp_fclk_i | input | 1 | Frame clock forwarded in bypass mode |
| bclk_o | output | 1 | Output bit clock (64 times the sample rate) |
| fclk_o | output | 1 | Output frame clock (the sample rate) |
| mode_err_o | output | 1 | High while the captured mode is reserved |
| div_run_o | output | 1 | High while the dividers are running |

## Verification
The checker watches, on every cycle, that the outputs stay quiet under power-down, in slave mode and in reserved modes. It also checks that the captured mode does not move once power-down is low, and that every frame clock transition lines up with a falling edge of the bit clock. Exact division ratios, duty cycle, the edge counts of the first rises after release, and bypass pass-through can only be shown by the bench's scenarios. In those scenarios the bench counts master clock edges for every mode, including runs in which the mode word is changed mid-operation.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef enum logic [2:0] {
    MD_R256   = 3'b000,
    MD_R384   = 3'b001,
    MD_R512   = 3'b010,
    MD_R768   = 3'b011,
    MD_SLAVE  = 3'b100,
    MD_RSV5   = 3'b101,
    MD_RSV6   = 3'b110,
    MD_BYPASS = 3'b111
  } clk_mode_e;

  // widest half-period count is 6 master clocks
  localparam int HALF_W = 3;

  // half of the bit-clock period, in master clocks
  function automatic logic [HALF_W-1:0] half_of(clk_mode_e m);
    case (m)
      MD_R256: half_of = HALF_W'(2);
      MD_R384: half_of = HALF_W'(3);
      MD_R512: half_of = HALF_W'(4);
      MD_R768: half_of = HALF_W'(6);
      default: half_of = HALF_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/aclk_rst_sync.sv
module aclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/aclk_mode_ctrl.sv
module aclk_mode_ctrl
  import aclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrdn,
  input  logic [2:0]        mode_in,
  output clk_mode_e         mode_q,
  output logic              is_div,
  output logic              is_bypass,
  output logic              is_rsvd,
  output logic [HALF_W-1:0] half_val
);
  clk_mode_e mode_d;

  // capture enable: power-down high
  always_comb mode_d = pwrdn ? clk_mode_e'(mode_in) : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_SLAVE;
    else        mode_q <= mode_d;
  end

  always_comb begin
    is_div    = (mode_q[2] == 1'b0);
    is_bypass = (mode_q == MD_BYPASS);
    is_rsvd   = (mode_q == MD_RSV5) || (mode_q == MD_RSV6);
    half_val  = half_of(mode_q);
  end
endmodule

// File: rtl/aclk_divider.sv
module aclk_divider
  import aclk_pkg::*;
#(
  parameter int FRAME_BCLKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_val,
  output logic              bclk,
  output logic              fclk
);
  localparam int FB_W = $clog2(FRAME_BCLKS / 2);
  localparam logic [FB_W-1:0] BC_LAST = FB_W'(FRAME_BCLKS / 2 - 1);

  logic [HALF_W-1:0] hc_q, hc_d;
  logic [FB_W-1:0]   bc_q, bc_d;
  logic              bclk_q, bclk_d;
  logic              fclk_q, fclk_d;
  logic              half_end;
  logic              fall_en;

  always_comb begin
    half_end = run && (hc_q == half_val - HALF_W'(1));
    fall_en  = half_end && bclk_q;

    hc_d   = '0;
    bclk_d = 1'b0;
    bc_d   = '0;
    fclk_d = 1'b0;
    if (run) begin
      hc_d   = half_end ? '0 : hc_q + HALF_W'(1);
      bclk_d = half_end ? ~bclk_q : bclk_q;
      bc_d   = bc_q;
      fclk_d = fclk_q;
      if (fall_en) begin
        bc_d = (bc_q == BC_LAST) ? '0 : bc_q + FB_W'(1);
        if (bc_q == BC_LAST) fclk_d = ~fclk_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q   <= '0;
      bc_q   <= '0;
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else begin
      hc_q   <= hc_d;
      bc_q   <= bc_d;
      bclk_q <= bclk_d;
      fclk_q <= fclk_d;
    end
  end

  assign bclk = bclk_q;
  assign fclk = fclk_q;
endmodule

// File: rtl/aud_mclk_gen.sv
module aud_mclk_gen
  import aclk_pkg::*;
#(
  parameter int FRAME_BCLKS = 64,
  parameter int RST_STAGES  = 2
) (
  input  logic       mclk_i,
  input  logic       rst_n_i,
  input  logic       pwrdn_i,
  input  logic [2:0] mode_i,
  input  logic       byp_bclk_i,
  input  logic       byp_fclk_i,
  output logic       bclk_o,
  output logic       fclk_o,
  output logic       mode_err_o,
  output logic       div_run_o
);
  logic              srst_n;
  clk_mode_e         lat_mode;
  logic              is_div, is_bypass, is_rsvd;
  logic [HALF_W-1:0] half_val;
  logic              run;
  logic              div_bclk, div_fclk;

  aclk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (mclk_i),
    .arst_n (rst_n_i),
    .srst_n (srst_n)
  );

  aclk_mode_ctrl u_mode (
    .clk       (mclk_i),
    .rst_n     (srst_n),
    .pwrdn     (pwrdn_i),
    .mode_in   (mode_i),
    .mode_q    (lat_mode),
    .is_div    (is_div),
    .is_bypass (is_bypass),
    .is_rsvd   (is_rsvd),
    .half_val  (half_val)
  );

  assign run = is_div && !pwrdn_i;

  aclk_divider #(.FRAME_BCLKS(FRAME_BCLKS)) u_div (
    .clk      (mclk_i),
    .rst_n    (srst_n),
    .run      (run),
    .half_val (half_val),
    .bclk     (div_bclk),
    .fclk     (div_fclk)
  );

  always_comb begin
    bclk_o = 1'b0;
    fclk_o = 1'b0;
    if (run) begin
      bclk_o = div_bclk;
      fclk_o = div_fclk;
    end else if (is_bypass && !pwrdn_i) begin
      bclk_o = byp_bclk_i;
      fclk_o = byp_fclk_i;
    end
  end

  assign mode_err_o = is_rsvd;
  assign div_run_o  = run;
endmodule

// File: rtl/aud_mclk_gen_chk.sv
module aud_mclk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwrdn,
  input logic       bclk,
  input logic       fclk,
  input logic       err,
  input logic       run,
  input logic [2:0] lat_mode
);
  // R3
  pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |-> (!bclk && !fclk && !run));

  // R6
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!bclk && !fclk && !run));

  // R5
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_mode == 3'b100) |-> (!bclk && !fclk && !err && !run));

  // R4
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwrdn && !$past(pwrdn)) |-> $stable(lat_mode));

  // R2
  fclk_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (fclk != $past(fclk))) |-> $fell(bclk));
endmodule

bind aud_mclk_gen aud_mclk_gen_chk u_chk (
  .clk      (mclk_i),
  .rst_n    (rst_n_i),
  .pwrdn    (pwrdn_i),
  .bclk     (bclk_o),
  .fclk     (fclk_o),
  .err      (mode_err_o),
  .run      (div_run_o),
  .lat_mode (lat_mode)
);

// File: tb/sim_aud_mclk_gen.sv
`timescale 1ns/1ps
module sim_aud_mclk_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwrdn;
  logic [2:0] mode;
  logic       byp_b, byp_f;
  logic       bclk, fclk, err, run;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  aud_mclk_gen u0 (
    .mclk_i     (clk),
    .rst_n_i    (rst_n),
    .pwrdn_i    (pwrdn),
    .mode_i     (mode),
    .byp_bclk_i (byp_b),
    .byp_fclk_i (byp_f),
    .bclk_o     (bclk),
    .fclk_o     (fclk),
    .mode_err_o (err),
    .div_run_o  (run)
  );

  function automatic int exp_half(int m);
    case (m)
      0: return 2;
      1: return 3;
      2: return 4;
      3: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_mode(int m, bit flip);
    int h, n, lim;
    int first_b, first_f, b_rise, f_rise, bad_hi, bad_per, bad_f, bad_al;
    int f_hi, f_per, quiet_bad, byp_bad, err_bad;
    logic pb;
    h = exp_half(m);
    n = 2 * h;
    @(negedge clk);
    pwrdn = 1'b1;
    mode  = 3'($urandom_range(0, 7));
    @(negedge clk);
    mode = 3'(m);
    @(negedge clk);
    // R3
    chk(!bclk && !fclk && !run, "R3 quiet in power-down", {29'b0, bclk, fclk, run}, 0);
    pwrdn = 1'b0;
    lim = (h > 0) ? (128 * n + n + 4) : 200;
    first_b = -1; first_f = -1; b_rise = -1; f_rise = -1;
    bad_hi = 0; bad_per = 0; bad_f = 0; bad_al = 0; f_hi = -1; f_per = -1;
    quiet_bad = 0; byp_bad = 0; err_bad = 0;
    pb = 1'b0;
    for (int k = 1; k <= lim; k++) begin
      logic pf;
      pf = fclk;
      @(negedge clk);
      if (flip && k == 3) mode = 3'($urandom_range(0, 7));
      if (h > 0) begin
        if (bclk && !pb) begin
          if (first_b < 0) first_b = k;
          if (b_rise >= 0 && (k - b_rise) != n) bad_per++;
          b_rise = k;
        end
        if (!bclk && pb && (k - b_rise) != h) bad_hi++;
        if (fclk != pf) begin
          if (!(pb && !bclk)) bad_al++;
          if (fclk) begin
            if (first_f < 0) first_f = k;
            if (f_rise >= 0) f_per = k - f_rise;
            f_rise = k;
          end else begin
            f_hi = k - f_rise;
          end
        end
        if (err) err_bad++;
      end else if (m == 7) begin
        byp_b = 1'($urandom_range(0, 1));
        byp_f = 1'($urandom_range(0, 1));
        #0.5;
        if (bclk !== byp_b || fclk !== byp_f) byp_bad++;
        if (err) err_bad++;
      end else begin
        if (bclk || fclk || run) quiet_bad++;
        if (err !== (m == 5 || m == 6)) err_bad++;
      end
      pb = bclk;
    end
    if (h > 0) begin
      // R9
      chk(first_b == h, "R9 first bclk rise edge", first_b, h);
      chk(first_f == 32 * n, "R9 first fclk rise edge", first_f, 32 * n);
      // R1 (and R4 when flip)
      chk(bad_per == 0, flip ? "R1/R4 bclk period" : "R1 bclk period", bad_per, 0);
      chk(bad_hi == 0, "R1 bclk high time", bad_hi, 0);
      // R2
      chk(f_hi == 32 * n, "R2 fclk high time", f_hi, 32 * n);
      chk(f_per == 64 * n, "R2 fclk period", f_per, 64 * n);
      chk(bad_al == 0, "R2 fclk aligned to bclk fall", bad_al, 0);
      chk(err_bad == 0, "R1 no error flag", err_bad, 0);
    end else if (m == 7) begin
      // R7
      chk(byp_bad == 0, "R7 bypass forwarding", byp_bad, 0);
      chk(err_bad == 0, "R7 no error flag", err_bad, 0);
    end else if (m == 4) begin
      // R5
      chk(quiet_bad == 0 && err_bad == 0, "R5 slave quiet", quiet_bad + err_bad, 0);
    end else begin
      // R6
      chk(quiet_bad == 0, "R6 reserved outputs low", quiet_bad, 0);
      chk(err_bad == 0, "R6 error flag high", err_bad, 0);
    end
  endtask

  initial begin
    int bad;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pwrdn = 1'b0; mode = 3'b101; byp_b = 1'b1; byp_f = 1'b1;
    repeat (3) @(negedge clk);
    // R8
    chk(!bclk && !fclk && !err && !run, "R8 reset outputs low",
        {28'b0, bclk, fclk, err, run}, 0);
    rst_n = 1'b1;
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (bclk || fclk || err || run) bad++;
    end
    // R8: mode 101 on the input without power-down is not taken
    chk(bad == 0, "R8 default slave after reset", bad, 0);

    for (int m = 0; m < 8; m++) run_mode(m, 1'b0);
    for (int i = 0; i < 14; i++) run_mode($urandom_range(0, 7), 1'($urandom_range(0, 1)));
    run_mode(3, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule